// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address front end of a synchronous burst memory. On a clock edge where either of two active-low address strobes is low and all three chip enables are true, it captures a full external address. After that capture it steps through a four-beat burst. Only the two least significant address bits move. The higher bits keep the value captured at the load.

An active-low advance input moves the burst forward by one beat. While advance is high, the burst is suspended and the current address is presented again. A static order input selects how the low bits are sequenced:

- **Linear order:** the low bits are the start value plus the beat number, modulo 4.
- **Interleaved order:** the low bits are the start value XOR the beat number.

After the fourth beat the burst returns to its start value. A new address may be loaded on any cycle, including every cycle in a row.

The block presents the full current address and a two-bit beat index. Both come from registers, so they appear one clock after the edge that caused them.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe asserted and `adv_n` high, `addr_out` and `beat` are zero.
- R2: When `strb_ctl_n` is low and the chip is enabled on a rising edge, `addr_out` equals that edge's `addr_in` after the edge, and `beat` is 0. The chip is enabled when `cs_n` is 0, `cs_hi` is 1 and `cs2_n` is 0.
- R3: When `strb_cpu_n` is low and the chip is enabled, the address is loaded exactly as in R2.
- R4: When a strobe is low but `cs_hi` is 0 or `cs2_n` is 1, nothing is loaded and `addr_out` and `beat` keep their values.
- R5: While `cs_n` is 1, a low `strb_cpu_n` loads nothing and also does not advance the burst.
- R6: When both strobes are high and `adv_n` is low, `beat` increments by 1 modulo 4 at the edge.
- R7: When both strobes are high and `adv_n` is high, `addr_out` and `beat` hold.
- R8: When `order_lin_n` is 0 (linear order), `addr_out[1:0]` equals (start + `beat`) mod 4. For example, a start of 2 gives 2, 3, 0, 1.
- R9: When `order_lin_n` is 1 (interleaved order, the default), `addr_out[1:0]` equals start XOR `beat`. For example, a start of 1 gives 1, 0, 3, 2.
- R10: After four advances, `addr_out[1:0]` is back at the start value and `beat` is 0.
- R11: `addr_out[ADDR_W-1:2]` changes only on a load. No carry ever propagates into these bits.
- R12: Loads on consecutive cycles each take effect, so every cycle presents the newly captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Primary chip enable, active low; also gates the processor-side strobe |
| cs_hi | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Second chip enable, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_lin_n | input | 1 | Burst order: 0 selects linear, 1 selects interleaved |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | 2 | Beat index within the burst |

## Verification
The assertions are checked on every cycle. They cover:
- capture on a qualified strobe (R2, R3);
- the beat increment on advance (R6);
- the per-step relation of the low bits in each order (R8, R9);
- holding during suspend or a disabled strobe (R4, R5, R7);
- the upper bits being frozen outside loads (R11).

Some behaviours span several cycles, and only the bench scenarios show them:
- the return to the start value on the fifth beat (R10);
- the full sequence for every start value under both orders (R8, R9);
- a suspend placed in the middle of a burst (R7);
- uninterrupted back-to-back loads (R12).

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs_hi,
  input  logic              cs2_n,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              order_lin_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      base_q;
  logic [1:0]      beat_q;
  logic            chip_en;
  logic            any_strb;
  logic            load;
  logic            step;
  logic [1:0]      low;

  assign chip_en  = !cs_n && cs_hi && !cs2_n;
  assign any_strb = !strb_cpu_n || !strb_ctl_n;
  assign load     = chip_en && any_strb;
  assign step     = !any_strb && !adv_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= 2'd0;
      beat_q <= 2'd0;
    end else if (load) begin
      hi_q   <= addr_in[ADDR_W-1:2];
      base_q <= addr_in[1:0];
      beat_q <= 2'd0;
    end else if (step) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign low      = order_lin_n ? (base_q ^ beat_q) : (base_q + beat_q);
  assign addr_out = {hi_q, low};
  assign beat     = beat_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              cs_hi,
  input logic              cs2_n,
  input logic              strb_cpu_n,
  input logic              strb_ctl_n,
  input logic              adv_n,
  input logic              order_lin_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat
);
  logic en_c, strb_c, ld_c, st_c;
  assign en_c   = !cs_n && cs_hi && !cs2_n;
  assign strb_c = !strb_cpu_n || !strb_ctl_n;
  assign ld_c   = en_c && strb_c;
  assign st_c   = !strb_c && !adv_n;

  // R2 R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_c |=> (addr_out[ADDR_W-1:2] == $past(addr_in[ADDR_W-1:2])) && (beat == 2'd0)
             && (addr_out[1:0] == $past(addr_in[1:0])));

  // R6
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_c |=> beat == $past(beat) + 2'd1);

  // R8
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_c && !order_lin_n) |=> (order_lin_n || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  // R9
  xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_c && order_lin_n) |=> (!order_lin_n ||
      ((addr_out[1:0] ^ beat) == ($past(addr_out[1:0]) ^ $past(beat)))));

  // R4 R5 R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_c && !st_c) |=> $stable(beat) && $stable(addr_out[ADDR_W-1:2]));

  // R11
  upper_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_c |=> $stable(addr_out[ADDR_W-1:2]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .cs2_n(cs2_n),
  .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
  .order_lin_n(order_lin_n), .addr_in(addr_in), .addr_out(addr_out), .beat(beat)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, cs_hi = 1'b1, cs2_n = 1'b0;
  logic strb_cpu_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1, order_lin_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [AW-3:0] e_hi = '0;
  logic [1:0]    e_base = 2'd0;
  logic [1:0]    e_beat = 2'd0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .cs2_n(cs2_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .order_lin_n(order_lin_n), .addr_in(addr_in), .addr_out(addr_out), .beat(beat)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = order_lin_n ? (e_base ^ e_beat) : 2'((int'(e_base) + int'(e_beat)) % 4);
    return {e_hi, lo};
  endfunction

  task automatic check(input string tag);
    compared++;
    if (addr_out !== exp_addr() || beat !== e_beat) begin
      mismatched++;
      $display("FAIL %s: addr_out=%h beat=%0d expected addr_out=%h beat=%0d",
               tag, addr_out, beat, exp_addr(), e_beat);
    end
  endtask

  task automatic go(input string tag);
    logic en;
    @(posedge clk);
    en = !cs_n && cs_hi && !cs2_n;
    if (en && (!strb_cpu_n || !strb_ctl_n)) begin
      e_hi = addr_in[AW-1:2]; e_base = addr_in[1:0]; e_beat = 2'd0;
    end else if (strb_cpu_n && strb_ctl_n && !adv_n) begin
      e_beat = 2'((int'(e_beat) + 1) % 4);
    end
    #2;
    check(tag);
  endtask

  task automatic idle();
    cs_n = 0; cs_hi = 1; cs2_n = 0; strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
  endtask

  initial begin
    #3000000;
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 in reset");
    rst_n = 1;
    go("R1 after release");

    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        for (int u = 0; u < 2; u++) begin
          order_lin_n = o[0];
          addr_in = {(u == 0) ? 6'h15 : 6'h3F, s[1:0]};
          strb_ctl_n = 0;
          go("R2 controller load");
          strb_ctl_n = 1;
          addr_in = ~addr_in;
          for (int k = 1; k <= 5; k++) begin
            if (k == 3) begin
              adv_n = 1;
              go("R7 suspend");
            end
            adv_n = 0;
            if (k == 4) go("R10 wrap to start");
            else if (k == 5) go("R11 upper bits frozen");
            else if (k == 1) go("R6 advance");
            else go(o ? "R9 interleaved" : "R8 linear");
          end
          adv_n = 1;
        end
      end
    end

    idle(); order_lin_n = 1;
    addr_in = 8'hA6; strb_ctl_n = 0;
    go("R2 setup");
    strb_ctl_n = 1; adv_n = 0;
    go("R6 setup advance");
    adv_n = 1; cs_hi = 0; strb_ctl_n = 0; addr_in = 8'h51;
    go("R4 cs_hi low");
    cs_hi = 1; cs2_n = 1; strb_cpu_n = 0;
    go("R4 cs2_n high");
    idle(); cs_n = 1; strb_cpu_n = 0; adv_n = 0;
    go("R5 cpu strobe ignored");
    go("R5 cpu strobe ignored again");
    idle(); strb_cpu_n = 0; addr_in = 8'h3B;
    go("R3 cpu load");
    for (int i = 0; i < 6; i++) begin
      addr_in = 8'(8'h40 + i * 37);
      if (i % 2 == 0) begin strb_cpu_n = 0; strb_ctl_n = 1; end
      else begin strb_cpu_n = 1; strb_ctl_n = 0; end
      go("R12 back-to-back load");
    end
    idle(); order_lin_n = 0; adv_n = 0;
    for (int i = 0; i < 4; i++) go("R8 linear after cpu load");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule